// File: doc/BRIEF.md
# Piecewise-Linear Gamma Evaluator

This block is a per-pixel colour correction stage for a display compositor. Each 12-bit colour component is mapped through its own programmable curve of 16 straight segments. Every segment holds an intercept (unsigned, 12 integer bits and 4 fractional bits) and a slope (unsigned, 4 integer bits and 8 fractional bits). A slope cannot be negative, so a falling stretch of a curve must be programmed flat. The block keeps one red, one green and one blue curve for each of three display channels. Only channel 2 also has an alpha curve.

Each pixel arrives with a channel index and a per-pixel correction enable. The top four bits of a component select the segment and the low eight bits give the offset into it. The block computes intercept plus slope times offset, rounds the result to an integer and clamps it to 12 bits. When correction is off, or no curve exists for that component on that channel, the component passes through unchanged. Either way the result appears after a fixed three-stage pipeline.

Software loads the curves through a simple word-wide write/read port. Each segment occupies two adjacent words: one packs the segment start point and the intercept, the other holds the slope.

Top module: `pwl_gamma`

## Requirements
- R1: After reset, every segment s of every existing curve reads back as an identity curve: start point s*256 in bits [27:16] and intercept s*4096 in bits [15:0] of the first word, and slope 0x100 in bits [11:0] of the second word. `out_valid_o` is low.
- R2: The word address is chan*128 + comp*32 + seg*2 + w. Here comp is 0 red, 1 green, 2 blue, 3 alpha, and w is 0 for the start/intercept word and 1 for the slope word. A write updates only the addressed field set of that one segment.
- R3: `reg_rdata_o` holds, one cycle after an address is presented, the stored word at that address. Bits that have no storage read as zero: bits [31:28] of the first word and bits [31:12] of the second. Writes to those bits are dropped.
- R4: With correction enabled, component value v is mapped as follows: seg = v[11:8], off = v[7:0], out = min(4095, (C*16 + G*off + 128) >> 8). C and G are that segment's intercept and slope.
- R5: A result above 4095 is clamped to 4095.
- R6: Fractional results round half up. An exact half (intercept 0x0008, slope 0) gives 1, and intercept 0x0007 gives 0.
- R7: With `gam_en_i` low, all four components leave the block unchanged.
- R8: Only channel 2 has an alpha curve. Alpha on channels 0 and 1 passes through unchanged. Their alpha words ignore writes and read zero. Channel index 3 passes every component through, and its addresses (384 and above) ignore writes and read zero.
- R9: A pixel sampled with `pix_valid_i` high shows its result with `out_valid_o` high exactly three rising edges later. Pixels may arrive on every cycle.
- R10: A segment write presented in the same cycle as a pixel, or earlier, is used for that pixel. A pixel sampled in an earlier cycle still uses the old value.
- R11: The curves of different channels are independent. Programming one channel's curve leaves the results of the other channels unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_we_i | input | 1 | Table write strobe |
| reg_addr_i | input | 9 | Table word address |
| reg_wdata_i | input | 32 | Table write data |
| reg_rdata_o | output | 32 | Table read data, one cycle after the address |
| pix_valid_i | input | 1 | Input pixel valid |
| pix_chan_i | input | 2 | Display channel of the pixel |
| gam_en_i | input | 1 | Correction enable for this pixel |
| pix_r_i | input | 12 | Red in |
| pix_g_i | input | 12 | Green in |
| pix_b_i | input | 12 | Blue in |
| pix_a_i | input | 12 | Alpha in |
| out_valid_o | output | 1 | Output pixel valid |
| out_r_o | output | 12 | Red out |
| out_g_o | output | 12 | Green out |
| out_b_o | output | 12 | Blue out |
| out_a_o | output | 12 | Alpha out |

## Verification
The assertions watch four things on every cycle: the three-edge valid latency, unchanged pass-through when correction is off, zero reads from the missing alpha tables, and slope write/read-back coherence. The segment arithmetic, clamping and half-up rounding can only be shown by the bench's scenarios, which compare every output against a behavioural curve model. The same holds for the same-cycle write ordering and the independence of channels. A long mixed stream with random writes interleaved with pixels covers the interactions between these behaviours.

// File: rtl/gam_pkg.sv
package gam_pkg;
  localparam int unsigned PIX_W       = 12;
  localparam int unsigned SEG_W       = 4;
  localparam int unsigned OFF_W       = PIX_W - SEG_W;
  localparam int unsigned NUM_SEG     = 1 << SEG_W;
  localparam int unsigned C_W         = 16;  // U12.4
  localparam int unsigned C_FRAC      = 4;
  localparam int unsigned G_W         = 12;  // U4.8
  localparam int unsigned G_FRAC      = 8;
  localparam int unsigned NUM_COMP    = 4;
  localparam int unsigned COMP_W      = $clog2(NUM_COMP);
  localparam int unsigned COMP_ALPHA  = 3;
  localparam int unsigned DATA_W      = 32;
  localparam int unsigned X_LSB       = 16;

  typedef struct packed {
    logic [PIX_W-1:0] x;
    logic [C_W-1:0]   c;
    logic [G_W-1:0]   g;
  } seg_t;
endpackage

// File: rtl/gam_table.sv
module gam_table import gam_pkg::*; #(
  parameter  int unsigned NUM_CHAN   = 3,
  parameter  int unsigned ALPHA_CHAN = 2,
  localparam int unsigned CH_W       = (NUM_CHAN > 1) ? $clog2(NUM_CHAN) : 1,
  localparam int unsigned AW         = CH_W + COMP_W + SEG_W + 1
) (
  input  logic                             clk_i,
  input  logic                             rst_ni,
  input  logic                             we_i,
  input  logic [AW-1:0]                    addr_i,
  input  logic [DATA_W-1:0]                wdata_i,
  output logic [DATA_W-1:0]                rdata_o,
  input  logic [CH_W-1:0]                  lk_chan_i,
  input  logic [NUM_COMP-1:0][SEG_W-1:0]   lk_seg_i,
  output seg_t [NUM_COMP-1:0]              lk_o
);
  logic [CH_W-1:0]   a_ch;
  logic [COMP_W-1:0] a_comp;
  logic [SEG_W-1:0]  a_seg;
  logic              a_w;
  assign {a_ch, a_comp, a_seg, a_w} = addr_i;

  logic unused_wdata;
  assign unused_wdata = ^wdata_i[DATA_W-1:X_LSB+PIX_W];

  seg_t view [NUM_CHAN][NUM_COMP][NUM_SEG];

  for (genvar c = 0; c < NUM_CHAN; c++) begin : g_ch
    for (genvar k = 0; k < NUM_COMP; k++) begin : g_comp
      if (k != COMP_ALPHA || c == ALPHA_CHAN) begin : g_mem
        seg_t tbl [NUM_SEG];
        logic hit;
        assign hit = we_i && (a_ch == CH_W'(c)) && (a_comp == COMP_W'(k));
        always_ff @(posedge clk_i or negedge rst_ni) begin
          if (!rst_ni) begin
            for (int s = 0; s < NUM_SEG; s++) begin
              tbl[s].x <= PIX_W'(s) << OFF_W;
              tbl[s].c <= C_W'(s) << (OFF_W + C_FRAC);
              tbl[s].g <= G_W'(1) << G_FRAC;
            end
          end else if (hit) begin
            if (a_w) begin
              tbl[a_seg].g <= wdata_i[G_W-1:0];
            end else begin
              tbl[a_seg].x <= wdata_i[X_LSB +: PIX_W];
              tbl[a_seg].c <= wdata_i[C_W-1:0];
            end
          end
        end
        for (genvar s = 0; s < NUM_SEG; s++) begin : g_s
          assign view[c][k][s] = tbl[s];
        end
      end else begin : g_none
        for (genvar s = 0; s < NUM_SEG; s++) begin : g_s
          assign view[c][k][s] = '0;
        end
      end
    end
  end

  // read side: unmapped regions return zero
  logic              a_ok;
  logic [CH_W-1:0]   a_ch_s;
  logic [CH_W-1:0]   lk_ch_s;
  seg_t              rd_seg;
  logic [DATA_W-1:0] rd_word;

  assign a_ok   = (32'(a_ch) < NUM_CHAN) &&
                  ((32'(a_comp) != COMP_ALPHA) || (32'(a_ch) == ALPHA_CHAN));
  assign a_ch_s = (32'(a_ch) < NUM_CHAN) ? a_ch : '0;
  assign rd_seg = a_ok ? view[a_ch_s][a_comp][a_seg] : '0;
  assign rd_word = a_w ? DATA_W'(rd_seg.g) : DATA_W'({rd_seg.x, rd_seg.c});

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rdata_o <= '0;
    else         rdata_o <= rd_word;
  end

  assign lk_ch_s = (32'(lk_chan_i) < NUM_CHAN) ? lk_chan_i : '0;
  for (genvar k = 0; k < NUM_COMP; k++) begin : g_lk
    assign lk_o[k] = view[lk_ch_s][k][lk_seg_i[k]];
  end

  // missing alpha tables never return data
  assert_alpha_absent_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (32'(a_comp) == COMP_ALPHA && 32'(a_ch) != ALPHA_CHAN) |=> (rdata_o == '0));

  // slope written then read at the same address comes back masked
  assert_slope_readback_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && a_w && a_ok) ##1 (addr_i == $past(addr_i)) |=>
      (rdata_o == DATA_W'($past(wdata_i[G_W-1:0], 2))));
endmodule

// File: rtl/gam_seg_eval.sv
module gam_seg_eval import gam_pkg::*; (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             byp_i,
  input  logic [PIX_W-1:0] raw_i,
  input  seg_t             seg_i,
  input  logic [OFF_W-1:0] off_i,
  output logic [PIX_W-1:0] res_o
);
  localparam int unsigned ALIGN   = G_FRAC - C_FRAC;
  localparam int unsigned PROD_W  = G_W + OFF_W;
  localparam int unsigned ACC_W   = (((C_W + ALIGN) > PROD_W) ? (C_W + ALIGN) : PROD_W) + 1;
  localparam int unsigned WHOLE_W = ACC_W - G_FRAC;
  localparam logic [WHOLE_W-1:0] WHOLE_MAX = WHOLE_W'((1 << PIX_W) - 1);

  logic unused_x;
  assign unused_x = ^seg_i.x;

  logic              byp1;
  logic [PIX_W-1:0]  raw1;
  logic [C_W-1:0]    c1;
  logic [PROD_W-1:0] prod1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      byp1  <= 1'b0;
      raw1  <= '0;
      c1    <= '0;
      prod1 <= '0;
    end else begin
      byp1  <= byp_i;
      raw1  <= raw_i;
      c1    <= seg_i.c;
      prod1 <= PROD_W'(seg_i.g) * PROD_W'(off_i);
    end
  end

  logic [ACC_W-1:0]   acc;
  logic [WHOLE_W-1:0] whole;
  logic [PIX_W-1:0]   res_n;

  // both terms in 1/256 units, plus half an LSB for rounding
  assign acc   = ACC_W'({c1, {ALIGN{1'b0}}}) + ACC_W'(prod1) + ACC_W'(1 << (G_FRAC - 1));
  assign whole = WHOLE_W'(acc >> G_FRAC);

  always_comb begin
    if (byp1)                   res_n = raw1;
    else if (whole > WHOLE_MAX) res_n = '1;
    else                        res_n = whole[PIX_W-1:0];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) res_o <= '0;
    else         res_o <= res_n;
  end
endmodule

// File: rtl/pwl_gamma.sv
module pwl_gamma import gam_pkg::*; #(
  parameter  int unsigned NUM_CHAN   = 3,
  parameter  int unsigned ALPHA_CHAN = 2,
  localparam int unsigned CH_W       = (NUM_CHAN > 1) ? $clog2(NUM_CHAN) : 1,
  localparam int unsigned AW         = CH_W + COMP_W + SEG_W + 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_we_i,
  input  logic [AW-1:0]     reg_addr_i,
  input  logic [DATA_W-1:0] reg_wdata_i,
  output logic [DATA_W-1:0] reg_rdata_o,
  input  logic              pix_valid_i,
  input  logic [CH_W-1:0]   pix_chan_i,
  input  logic              gam_en_i,
  input  logic [PIX_W-1:0]  pix_r_i,
  input  logic [PIX_W-1:0]  pix_g_i,
  input  logic [PIX_W-1:0]  pix_b_i,
  input  logic [PIX_W-1:0]  pix_a_i,
  output logic              out_valid_o,
  output logic [PIX_W-1:0]  out_r_o,
  output logic [PIX_W-1:0]  out_g_o,
  output logic [PIX_W-1:0]  out_b_o,
  output logic [PIX_W-1:0]  out_a_o
);
  logic [NUM_COMP-1:0][PIX_W-1:0] px_in;
  assign px_in = {pix_a_i, pix_b_i, pix_g_i, pix_r_i};

  logic                           v0, v1, v2;
  logic [CH_W-1:0]                ch0;
  logic                           en0;
  logic [NUM_COMP-1:0][PIX_W-1:0] px0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      v0  <= 1'b0;
      v1  <= 1'b0;
      v2  <= 1'b0;
      ch0 <= '0;
      en0 <= 1'b0;
      px0 <= '0;
    end else begin
      v0  <= pix_valid_i;
      v1  <= v0;
      v2  <= v1;
      ch0 <= pix_chan_i;
      en0 <= gam_en_i;
      px0 <= px_in;
    end
  end

  logic [NUM_COMP-1:0][SEG_W-1:0] lk_seg;
  seg_t [NUM_COMP-1:0]            lk;
  logic [NUM_COMP-1:0][PIX_W-1:0] res;
  logic                           ch_ok;

  assign ch_ok = (32'(ch0) < NUM_CHAN);

  gam_table #(
    .NUM_CHAN   (NUM_CHAN),
    .ALPHA_CHAN (ALPHA_CHAN)
  ) u_table (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .we_i      (reg_we_i),
    .addr_i    (reg_addr_i),
    .wdata_i   (reg_wdata_i),
    .rdata_o   (reg_rdata_o),
    .lk_chan_i (ch0),
    .lk_seg_i  (lk_seg),
    .lk_o      (lk)
  );

  for (genvar k = 0; k < NUM_COMP; k++) begin : g_comp
    logic byp;
    assign lk_seg[k] = px0[k][PIX_W-1 -: SEG_W];
    if (k == COMP_ALPHA) begin : g_alpha
      assign byp = !en0 || !ch_ok || (ch0 != CH_W'(ALPHA_CHAN));
    end else begin : g_col
      assign byp = !en0 || !ch_ok;
    end
    gam_seg_eval u_eval (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .byp_i  (byp),
      .raw_i  (px0[k]),
      .seg_i  (lk[k]),
      .off_i  (px0[k][OFF_W-1:0]),
      .res_o  (res[k])
    );
  end

  assign out_valid_o = v2;
  assign out_r_o     = res[0];
  assign out_g_o     = res[1];
  assign out_b_o     = res[2];
  assign out_a_o     = res[3];

  assert_valid_latency_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pix_valid_i |-> ##3 out_valid_o);

  assert_no_spurious_valid_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pix_valid_i |-> ##3 !out_valid_o);

  assert_bypass_passthrough_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pix_valid_i && !gam_en_i) |-> ##3
      ((out_r_o == $past(pix_r_i, 3)) && (out_g_o == $past(pix_g_i, 3)) &&
       (out_b_o == $past(pix_b_i, 3)) && (out_a_o == $past(pix_a_i, 3))));
endmodule

// File: tb/test_pwl_gamma.sv
module test_pwl_gamma;
  localparam int CLK_P = 10;
  localparam int NCH   = 3;
  localparam int NSEG  = 16;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_we = 1'b0;
  logic [8:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        pix_valid = 1'b0;
  logic [1:0]  pix_chan = '0;
  logic        gam_en = 1'b0;
  logic [11:0] pix_r = '0, pix_g = '0, pix_b = '0, pix_a = '0;
  logic        out_valid;
  logic [11:0] out_r, out_g, out_b, out_a;

  always #(CLK_P/2) clk = ~clk;

  pwl_gamma i_pwl_gamma (
    .clk_i(clk), .rst_ni(rst_n),
    .reg_we_i(reg_we), .reg_addr_i(reg_addr), .reg_wdata_i(reg_wdata), .reg_rdata_o(reg_rdata),
    .pix_valid_i(pix_valid), .pix_chan_i(pix_chan), .gam_en_i(gam_en),
    .pix_r_i(pix_r), .pix_g_i(pix_g), .pix_b_i(pix_b), .pix_a_i(pix_a),
    .out_valid_o(out_valid), .out_r_o(out_r), .out_g_o(out_g), .out_b_o(out_b), .out_a_o(out_a)
  );

  int checks = 0;
  int failures = 0;
  bit done = 0;

  int mx [NCH][4][NSEG];
  int mc [NCH][4][NSEG];
  int mg [NCH][4][NSEG];

  bit    hv [3];
  int    hd [3][4];
  string htag [3];
  int    rd_exp;
  string rd_tag;

  function automatic int adr(int ch, int k, int s, int w);
    return ch * 128 + k * 32 + s * 2 + w;
  endfunction

  function automatic bit has_tbl(int ch, int k);
    return (ch < NCH) && (k != 3 || ch == 2);
  endfunction

  function automatic int model_read(int addr);
    int ch = addr >> 7;
    int k  = (addr >> 5) & 3;
    int s  = (addr >> 1) & 15;
    if (!has_tbl(ch, k)) return 0;
    if (addr & 1) return mg[ch][k][s];
    return (mx[ch][k][s] << 16) | mc[ch][k][s];
  endfunction

  function automatic void model_write(int addr, logic [31:0] wd);
    int ch = addr >> 7;
    int k  = (addr >> 5) & 3;
    int s  = (addr >> 1) & 15;
    if (!has_tbl(ch, k)) return;
    if (addr & 1) mg[ch][k][s] = int'(wd[11:0]);
    else begin
      mx[ch][k][s] = int'(wd[27:16]);
      mc[ch][k][s] = int'(wd[15:0]);
    end
  endfunction

  function automatic int model_pix(int ch, bit en, int k, int v);
    int s, o, t;
    if (!en || !has_tbl(ch, k)) return v;
    s = v >> 8;
    o = v & 255;
    t = (mc[ch][k][s] * 16 + mg[ch][k][s] * o + 128) >> 8;
    return (t > 4095) ? 4095 : t;
  endfunction

  task automatic chk(bit ok, string tag, string what, int act, int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s act=%0h exp=%0h", tag, what, act, exp);
    end
  endtask

  task automatic step(bit pv, int ch, bit en, int r, int g, int b, int a,
                      bit we, int addr, logic [31:0] wd, string tag);
    int px [4];
    @(negedge clk);
    chk(out_valid === hv[2], htag[2], "out_valid", int'(out_valid), int'(hv[2]));
    if (hv[2]) begin
      chk(int'(out_r) == hd[2][0], htag[2], "out_r", int'(out_r), hd[2][0]);
      chk(int'(out_g) == hd[2][1], htag[2], "out_g", int'(out_g), hd[2][1]);
      chk(int'(out_b) == hd[2][2], htag[2], "out_b", int'(out_b), hd[2][2]);
      chk(int'(out_a) == hd[2][3], htag[2], "out_a", int'(out_a), hd[2][3]);
    end
    chk(int'(reg_rdata) == rd_exp, rd_tag, "rdata", int'(reg_rdata), rd_exp);
    pix_valid = pv; pix_chan = ch[1:0]; gam_en = en;
    pix_r = r[11:0]; pix_g = g[11:0]; pix_b = b[11:0]; pix_a = a[11:0];
    reg_we = we; reg_addr = addr[8:0]; reg_wdata = wd;
    rd_exp = model_read(addr);
    rd_tag = tag;
    if (we) model_write(addr, wd);
    px = '{r, g, b, a};
    hv[2] = hv[1]; hd[2] = hd[1]; htag[2] = htag[1];
    hv[1] = hv[0]; hd[1] = hd[0]; htag[1] = htag[0];
    hv[0] = pv;
    for (int k = 0; k < 4; k++) hd[0][k] = model_pix(ch, en, k, px[k]);
    htag[0] = tag;
  endtask

  task automatic px(int ch, bit en, int r, int g, int b, int a, string tag);
    step(1'b1, ch, en, r, g, b, a, 1'b0, 0, '0, tag);
  endtask

  task automatic wr(int addr, logic [31:0] wd, string tag);
    step(1'b0, 0, 1'b0, 0, 0, 0, 0, 1'b1, addr, wd, tag);
  endtask

  task automatic rd(int addr, string tag);
    step(1'b0, 0, 1'b0, 0, 0, 0, 0, 1'b0, addr, '0, tag);
  endtask

  initial begin
    #(CLK_P * 200000);
    if (!done) begin
      failures++;
      $display("FAIL R9 watchdog act=hung exp=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    for (int c = 0; c < NCH; c++)
      for (int k = 0; k < 4; k++)
        for (int s = 0; s < NSEG; s++) begin
          mx[c][k][s] = s << 8;
          mc[c][k][s] = s << 12;
          mg[c][k][s] = 256;
        end
    for (int i = 0; i < 3; i++) begin hv[i] = 0; htag[i] = "R1"; end
    rd_exp = 0;
    rd_tag = "R1";

    repeat (3) @(negedge clk);
    chk(out_valid == 1'b0, "R1", "reset valid", int'(out_valid), 0);
    chk(reg_rdata == '0, "R1", "reset rdata", int'(reg_rdata), 0);
    rst_n = 1'b1;

    // R1 identity contents after reset
    rd(adr(0, 0, 1, 0), "R1");
    rd(adr(0, 0, 1, 1), "R1");
    rd(adr(2, 3, 15, 0), "R1");
    rd(adr(1, 2, 7, 1), "R1");
    rd(0, "R1");

    // R4 identity mapping with correction on
    px(0, 1, 'h000, 'h123, 'h7FF, 'hFFF, "R4");
    px(1, 1, 'h456, 'h001, 'hFFE, 'h080, "R4");
    px(2, 1, 'h0FF, 'h100, 'hABC, 'h801, "R4");

    // R2 / R3 programming and read-back
    wr(adr(1, 1, 5, 0), 32'hF500_1234, "R2");
    wr(adr(1, 1, 5, 1), 32'hABCD_E180, "R2");
    rd(adr(1, 1, 5, 0), "R3");
    rd(adr(1, 1, 5, 1), "R3");
    rd(adr(1, 0, 5, 0), "R2");
    px(1, 1, 'h5A0, 'h5A0, 'h5A0, 'h5A0, "R4");
    px(0, 1, 'h5A0, 'h5A0, 'h5A0, 'h5A0, "R11");
    px(2, 1, 'h5A0, 'h5A0, 'h5A0, 'h5A0, "R11");

    // R5 saturation
    wr(adr(0, 2, 15, 0), 32'h0F00_FFF0, "R5");
    wr(adr(0, 2, 15, 1), 32'h0000_0FFF, "R5");
    px(0, 1, 0, 0, 'hFFF, 0, "R5");
    px(0, 1, 0, 0, 'hF00, 0, "R5");
    px(0, 1, 0, 0, 'hF40, 0, "R5");

    // R6 rounding
    wr(adr(0, 0, 0, 0), 32'h0000_0008, "R6");
    wr(adr(0, 0, 0, 1), 32'h0, "R6");
    wr(adr(0, 0, 1, 0), 32'h0100_0007, "R6");
    wr(adr(0, 0, 1, 1), 32'h0, "R6");
    px(0, 1, 'h050, 0, 0, 0, "R6");
    px(0, 1, 'h150, 0, 0, 0, "R6");

    // R7 bypass
    px(0, 0, 'h050, 'hFFF, 'hF00, 'h123, "R7");
    px(1, 0, 'h5A0, 'h5A0, 'h5A0, 'h5A0, "R7");

    // R8 alpha only on channel 2, channel 3 absent
    wr(adr(2, 3, 8, 0), 32'h0800_0100, "R8");
    wr(adr(2, 3, 8, 1), 32'h0, "R8");
    wr(adr(0, 3, 8, 0), 32'h0800_0100, "R8");
    wr(400, 32'h0000_0123, "R8");
    rd(adr(0, 3, 8, 0), "R8");
    rd(adr(2, 3, 8, 0), "R8");
    rd(400, "R8");
    px(2, 1, 0, 0, 0, 'h8AB, "R8");
    px(0, 1, 0, 0, 0, 'h8AB, "R8");
    px(3, 1, 'h5A0, 'h5A0, 'hFFF, 'h8AB, "R8");

    // R10 write ordering relative to pixels
    px(1, 1, 'h260, 0, 0, 0, "R10");
    step(1'b1, 1, 1'b1, 'h250, 0, 0, 0, 1'b1, adr(1, 0, 2, 0), 32'h0200_4000, "R10");
    px(1, 1, 'h2FF, 0, 0, 0, "R10");

    // R9 back-to-back mixed stream with interleaved writes
    for (int i = 0; i < 400; i++) begin
      bit wen = ($urandom_range(3, 0) == 0);
      step(1'b1, $urandom_range(3, 0), $urandom_range(1, 0),
           $urandom_range(4095, 0), $urandom_range(4095, 0),
           $urandom_range(4095, 0), $urandom_range(4095, 0),
           wen, $urandom_range(511, 0), $urandom, "R9");
    end
    for (int i = 0; i < 5; i++) rd(0, "R9");

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule